// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a processor that reaches them through a rotating window. Each instruction names one of 32 architectural registers with a 5-bit index. The current window number, supplied by the surrounding pipeline, chooses which physical registers that index selects. Indices 1 to 7 are globals, shared by every window. Index 0 is a constant zero. Each window has eight private locals. It also has two groups of eight that overlap its neighbours: its outs are the ins of the previous window, and its ins are the outs of the next window.

There is one write port and one combinational read port, and both use the current window. The block also gives the window numbers on either side of the current one, wrapping at the window count. The pipeline uses these when it moves the pointer. Physical storage is 8 globals plus 16 registers per window. The overlap comes from address mapping, so no register is stored twice.

Top module: `win_regfile`

## Requirements
- R1: A read of index 0 returns zero in every window, and a write to index 0 changes no register.
- R2: A write to an index from 1 to 7 reads back the same value at that index in every window.
- R3: A write to an index r from 8 to 15 in window w reads back at index r in w and at index r+16 in the previous window.
- R4: A write to an index r from 24 to 31 in window w reads back at index r in w and at index r-16 in the next window.
- R5: A write to an index from 16 to 23 in window w is visible only at that index in window w, and in no other window.
- R6: nextWin equals curWin+1 when curWin is below NUM_WIN-1, and 0 when curWin is NUM_WIN-1.
- R7: prevWin equals curWin-1 when curWin is above 0, and NUM_WIN-1 when curWin is 0.
- R8: A write with wrEn high takes effect at the next rising clock edge; a read of the same register in that cycle returns the old value.
- R9: With rst high at a rising clock edge, every register is cleared to zero (synchronous reset).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| curWin | input | $clog2(NUM_WIN) | Current window number, used by both ports |
| wrEn | input | 1 | Write enable |
| wrIdx | input | 5 | Architectural index to write |
| wrData | input | DATA_W | Write data |
| rdIdx | input | 5 | Architectural index to read |
| rdData | output | DATA_W | Read data (combinational) |
| nextWin | output | $clog2(NUM_WIN) | Window after curWin, wrapping |
| prevWin | output | $clog2(NUM_WIN) | Window before curWin, wrapping |

## Verification
The bench fills every index of every window with values that encode both the window and the index. It does this once in ascending window order and once in descending order with inverted data. After each pass it reads every window. The two orders separate the two aliasing cases. When an out register and the overlapping in register of a neighbour are both written, the later write must win, so a wrong bank or a wrong direction of wrap leaves the value from the other pass. Locals and the zero register show a leak into another window as a mismatch. A same-cycle write and read of one register separates old data from new data. A reset in the middle of the run, followed by a full sweep, shows the clear.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  localparam int REG_IDX_W   = 5;
  localparam int GLOBAL_CNT  = 8;
  localparam int BANK_SPAN   = 16;
  localparam int GROUP_SIZE  = 8;

  typedef struct packed {
    logic wrStrobe;
    logic rdZero;
  } wrfStrobes_t;
endpackage

// File: rtl/wrf_ctrl.sv
module wrf_ctrl
  import wrf_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int WIN_W   = $clog2(NUM_WIN),
  parameter int PA_W    = $clog2(GLOBAL_CNT + BANK_SPAN * NUM_WIN)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [WIN_W-1:0]     curWin,
  input  logic                 wrEn,
  input  logic [REG_IDX_W-1:0] wrIdx,
  input  logic [REG_IDX_W-1:0] rdIdx,
  output logic [WIN_W-1:0]     nextWin,
  output logic [WIN_W-1:0]     prevWin,
  output logic [PA_W-1:0]      wrAddr,
  output logic [PA_W-1:0]      rdAddr,
  output wrfStrobes_t          strobes
);
  localparam logic [WIN_W-1:0] LAST_WIN = WIN_W'(NUM_WIN - 1);

  always_comb begin
    nextWin = (curWin == LAST_WIN) ? '0 : curWin + 1'b1;
    prevWin = (curWin == '0) ? LAST_WIN : curWin - 1'b1;
  end

  // Outs of a window live in the in-bank of the previous window.
  function automatic logic [PA_W-1:0] mapIdx(input logic [REG_IDX_W-1:0] idx,
                                             input logic [WIN_W-1:0] w,
                                             input logic [WIN_W-1:0] pw);
    int sel;
    int phys;
    sel = int'(idx);
    if (sel < GLOBAL_CNT)
      phys = sel;
    else if (sel < 2 * GROUP_SIZE)
      phys = GLOBAL_CNT + int'(pw) * BANK_SPAN + GROUP_SIZE + (sel - GROUP_SIZE);
    else if (sel < 3 * GROUP_SIZE)
      phys = GLOBAL_CNT + int'(w) * BANK_SPAN + (sel - 2 * GROUP_SIZE);
    else
      phys = GLOBAL_CNT + int'(w) * BANK_SPAN + GROUP_SIZE + (sel - 3 * GROUP_SIZE);
    return PA_W'(phys);
  endfunction

  always_comb begin
    wrAddr           = mapIdx(wrIdx, curWin, prevWin);
    rdAddr           = mapIdx(rdIdx, curWin, prevWin);
    strobes.wrStrobe = wrEn && (wrIdx != '0);
    strobes.rdZero   = (rdIdx == '0);
  end

  a_r6_next_wraps: assert property (@(posedge clk) disable iff (rst)
    (curWin == LAST_WIN) |-> (nextWin == '0));
  a_r7_prev_wraps: assert property (@(posedge clk) disable iff (rst)
    (curWin == '0) |-> (prevWin == LAST_WIN));
endmodule

// File: rtl/wrf_datapath.sv
module wrf_datapath
  import wrf_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int DATA_W  = 32,
  parameter int PA_W    = $clog2(GLOBAL_CNT + BANK_SPAN * NUM_WIN)
) (
  input  logic              clk,
  input  logic              rst,
  input  wrfStrobes_t       strobes,
  input  logic [PA_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [PA_W-1:0]   rdAddr,
  output logic [DATA_W-1:0] rdData
);
  localparam int PHYS = GLOBAL_CNT + BANK_SPAN * NUM_WIN;

  logic [DATA_W-1:0] regs [PHYS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PHYS; i++) regs[i] <= '0;
    end else if (strobes.wrStrobe) begin
      regs[wrAddr] <= wrData;
    end
  end

  assign rdData = strobes.rdZero ? '0 : regs[rdAddr];

  a_r8_write_lands: assert property (@(posedge clk) disable iff (rst)
    strobes.wrStrobe |=> (regs[$past(wrAddr)] == $past(wrData)));
endmodule

// File: rtl/win_regfile.sv
module win_regfile
  import wrf_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int DATA_W  = 32,
  localparam int WIN_W  = $clog2(NUM_WIN),
  localparam int PA_W   = $clog2(GLOBAL_CNT + BANK_SPAN * NUM_WIN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WIN_W-1:0]  curWin,
  input  logic              wrEn,
  input  logic [4:0]        wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [4:0]        rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic [WIN_W-1:0]  nextWin,
  output logic [WIN_W-1:0]  prevWin
);
  logic [PA_W-1:0] wrAddr;
  logic [PA_W-1:0] rdAddr;
  wrfStrobes_t     strobes;

  wrf_ctrl #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W), .PA_W(PA_W)) u_ctrl (
    .clk(clk), .rst(rst), .curWin(curWin), .wrEn(wrEn), .wrIdx(wrIdx),
    .rdIdx(rdIdx), .nextWin(nextWin), .prevWin(prevWin),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .strobes(strobes)
  );

  wrf_datapath #(.NUM_WIN(NUM_WIN), .DATA_W(DATA_W), .PA_W(PA_W)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );

  a_r1_zero_reads: assert property (@(posedge clk) disable iff (rst)
    (rdIdx == 5'd0) |-> (rdData == '0));
  a_r9_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (rdData == '0));
endmodule

// File: tb/win_regfile_bench.sv
`timescale 1ns/1ps
module win_regfile_bench;
  localparam int NW = 8;
  localparam int DW = 32;
  localparam int WW = $clog2(NW);

  logic          clk = 1'b0;
  logic          rst;
  logic [WW-1:0] curWin;
  logic          wrEn;
  logic [4:0]    wrIdx;
  logic [DW-1:0] wrData;
  logic [4:0]    rdIdx;
  logic [DW-1:0] rdData;
  logic [WW-1:0] nextWin;
  logic [WW-1:0] prevWin;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  logic [DW-1:0] model [NW][32];

  always #5 clk = ~clk;

  win_regfile #(.NUM_WIN(NW), .DATA_W(DW)) u_win_regfile (
    .clk(clk), .rst(rst), .curWin(curWin), .wrEn(wrEn), .wrIdx(wrIdx),
    .wrData(wrData), .rdIdx(rdIdx), .rdData(rdData),
    .nextWin(nextWin), .prevWin(prevWin)
  );

  function automatic int nxt(int w); return (w < NW - 1) ? w + 1 : 0; endfunction
  function automatic int prv(int w); return (w > 0) ? w - 1 : NW - 1; endfunction

  function automatic string tagOf(int r);
    if (r == 0) return "R1";
    if (r < 8) return "R2";
    if (r < 16) return "R3";
    if (r < 24) return "R5";
    return "R4";
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic modelClear();
    for (int w = 0; w < NW; w++)
      for (int r = 0; r < 32; r++) model[w][r] = '0;
  endtask

  task automatic modelWrite(int w, int r, logic [DW-1:0] d);
    if (r == 0) return;
    if (r < 8) begin
      for (int v = 0; v < NW; v++) model[v][r] = d;
    end else if (r < 16) begin
      model[w][r] = d;
      model[prv(w)][r + 16] = d;
    end else if (r < 24) begin
      model[w][r] = d;
    end else begin
      model[w][r] = d;
      model[nxt(w)][r - 16] = d;
    end
  endtask

  task automatic doWrite(int w, int r, logic [DW-1:0] d);
    @(negedge clk);
    curWin = WW'(w); wrIdx = 5'(r); wrData = d; wrEn = 1'b1;
    @(posedge clk);
    #1 wrEn = 1'b0;
    modelWrite(w, r, d);
  endtask

  task automatic sweep(string forced, string phase);
    for (int w = 0; w < NW; w++)
      for (int r = 0; r < 32; r++) begin
        @(negedge clk);
        curWin = WW'(w); rdIdx = 5'(r);
        #1;
        check((forced != "") ? forced : tagOf(r), rdData, model[w][r],
              $sformatf("%s win %0d idx %0d", phase, w, r));
      end
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wrEn = 1'b0; wrIdx = '0; rdIdx = '0; wrData = '0; curWin = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    modelClear();
    sweep("R9", "after reset");

    // R6 / R7: window neighbours for every pointer value
    for (int w = 0; w < NW; w++) begin
      @(negedge clk);
      curWin = WW'(w);
      #1;
      check("R6", DW'(nextWin), DW'(nxt(w)), $sformatf("next of %0d", w));
      check("R7", DW'(prevWin), DW'(prv(w)), $sformatf("prev of %0d", w));
    end

    // Pattern A: ascending windows
    for (int w = 0; w < NW; w++)
      for (int r = 0; r < 32; r++)
        doWrite(w, r, {8'hA5, 8'(w), 8'(r), 8'h3C});
    sweep("", "pattern A");

    // Pattern B: descending windows, inverted data
    for (int w = NW - 1; w >= 0; w--)
      for (int r = 31; r >= 0; r--)
        doWrite(w, r, ~{8'h5A, 8'(w), 8'(r), 8'hC3});
    sweep("", "pattern B");

    // R1: explicit zero-index write then read in each window
    for (int w = 0; w < NW; w++) begin
      doWrite(w, 0, 32'hFFFF_FFFF);
      @(negedge clk);
      rdIdx = 5'd0;
      #1 check("R1", rdData, '0, $sformatf("idx0 win %0d", w));
    end

    // R8: same-cycle read sees old value, new value after the edge
    @(negedge clk);
    curWin = WW'(2); wrIdx = 5'd17; rdIdx = 5'd17; wrData = 32'h1234_5678; wrEn = 1'b1;
    #1 check("R8", rdData, model[2][17], "read during write");
    @(posedge clk);
    #1 wrEn = 1'b0;
    modelWrite(2, 17, 32'h1234_5678);
    #1 check("R8", rdData, 32'h1234_5678, "read after edge");

    // R9: reset mid-run clears everything
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1 rst = 1'b0;
    modelClear();
    sweep("R9", "after second reset");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule